// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This block keeps asking a serial flash for its status and judges each answer. It raises a one-cycle request to a serial-shift front end, which runs the status-read command and returns the received bytes as a single word. The engine keeps the raw word. It compares only the bits selected by a per-bit mask, and only within the programmed byte count, against a programmed match value. Two match rules are available. In AND mode every selected bit must equal the match value. In OR mode one equal selected bit is enough.

Between reads the engine waits a programmed number of serial clock cycles, which it counts on a tick strobe from the clock generator. It can stop after the first match or keep polling until it is aborted. A sticky match flag and a read-done flag report results, and each has its own clear input. The configuration is captured only while the engine is idle, so values presented during a polling run have no effect on it.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy, rd_req, match_flag and done_flag are 0 and last_status is all zeros.
- R2: A start pulse while idle sets busy on the next clock edge and produces a one-cycle rd_req in the following cycle; rd_len carries the byte count minus one (0 = 1 byte … 3 = 4 bytes).
- R3: When a status word is accepted, last_status takes rx_data with no mask applied; byte lanes above the byte count (lane k holds bits 8k+7..8k) read as zero.
- R4: With any_mode = 0 (AND), a match occurs when every considered bit of the status equals the same bit of the match value.
- R5: With any_mode = 1 (OR), a match occurs when at least one considered bit equals the match value; with no considered bits there is no match.
- R6: A bit is considered only when its mask bit is 1 and its byte lane lies within the byte count.
- R7: match_flag is set on a match and stays set until clr_match is pulsed; a match in the same cycle as clr_match leaves it set.
- R8: done_flag is set by every accepted status word and cleared by a data_read pulse.
- R9: After a status word is accepted and polling continues, the next rd_req rises interval+1 clocks later when sclk_tick is high every cycle; the wait count advances only on cycles with sclk_tick high.
- R10: With stop_on_match = 1 a match ends polling (busy falls on the accepting edge, no more rd_req); with stop_on_match = 0 polling continues after a match.
- R11: abort returns the engine to idle on the next edge with busy low and no further rd_req, and abort wins over a status word arriving in the same cycle.
- R12: Configuration inputs changed while busy is high do not affect the running poll.
- R13: rx_valid outside the wait-for-status phase is ignored: last_status and done_flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mask | input | 32 | Per-bit compare enable (1 = compared) |
| cfg_match | input | 32 | Value the considered bits are compared with |
| cfg_any_mode | input | 1 | 0 = all considered bits must match, 1 = any one suffices |
| cfg_stop_on_match | input | 1 | 1 = end polling after the first match |
| cfg_interval | input | 16 | Serial clock cycles to wait between reads |
| cfg_nbytes_m1 | input | 2 | Status bytes per read minus one |
| start | input | 1 | Begin polling (taken while idle) |
| abort | input | 1 | Stop polling at once |
| sclk_tick | input | 1 | One pulse per serial clock cycle |
| rx_valid | input | 1 | Front end presents a completed status word |
| rx_data | input | 32 | Received status bytes, byte 0 in bits 7..0 |
| clr_match | input | 1 | Clears match_flag |
| data_read | input | 1 | Last-status read by software; clears done_flag |
| rd_req | output | 1 | One-cycle request to run a status read |
| rd_len | output | 2 | Byte count minus one for the requested read |
| match_flag | output | 1 | Sticky status-match flag |
| done_flag | output | 1 | A status read has completed |
| last_status | output | 32 | Most recent unmasked status word |
| busy | output | 1 | Polling is active |

## Verification
On every cycle the assertions watch the sequencing rules: rd_req is a lone pulse that follows a start from idle, abort and a stop-on-match result drop busy on the next edge, the flags hold and set as required, last_status moves only on an accepted word, and the captured configuration stays frozen while busy. The match arithmetic shows only in the bench scenarios, since its result depends on the data. These scenarios cover AND and OR rules, lane truncation by byte count and an empty mask. They also measure the exact gap between reads, with and without tick pauses, and show that settings written mid-run are ignored.

// File: rtl/poll_pkg.sv
// Shared types for the status auto-polling engine.
// Assumes: used by all poll_* modules and flash_status_poller.
package poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GAP   = 2'd3
    } poll_state_t;
endpackage

// File: rtl/poll_cfg_shadow.sv
// Configuration capture: follows the configuration inputs while the engine
// is idle and freezes them while a polling run is active.
// Assumes: busy comes from a register, so there is no combinational loop.
module poll_cfg_shadow #(
    parameter int DATA_W = 32,
    parameter int INT_W  = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [DATA_W-1:0] cfg_match,
    input  logic              cfg_any_mode,
    input  logic              cfg_stop_on_match,
    input  logic [INT_W-1:0]  cfg_interval,
    input  logic [CNT_W-1:0]  cfg_nbytes_m1,
    output logic [DATA_W-1:0] sh_mask,
    output logic [DATA_W-1:0] sh_match,
    output logic              sh_any_mode,
    output logic              sh_stop,
    output logic [INT_W-1:0]  sh_interval,
    output logic [CNT_W-1:0]  sh_nbytes_m1
);
    // Capture settings only while no run is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mask      <= '0;
            sh_match     <= '0;
            sh_any_mode  <= 1'b0;
            sh_stop      <= 1'b0;
            sh_interval  <= '0;
            sh_nbytes_m1 <= '0;
        end else if (!busy) begin
            sh_mask      <= cfg_mask;
            sh_match     <= cfg_match;
            sh_any_mode  <= cfg_any_mode;
            sh_stop      <= cfg_stop_on_match;
            sh_interval  <= cfg_interval;
            sh_nbytes_m1 <= cfg_nbytes_m1;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(sh_mask) && $stable(sh_match) && $stable(sh_interval)
                  && $stable(sh_any_mode) && $stable(sh_stop) && $stable(sh_nbytes_m1))); // R12
endmodule

// File: rtl/poll_match_eval.sv
// Match evaluation: builds the byte-lane enable from the byte count, then
// compares the considered bits under the AND or OR rule.
// Assumes: DATA_W is a multiple of 8; purely combinational.
module poll_match_eval #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 2
) (
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] match_val,
    input  logic [CNT_W-1:0]  nbytes_m1,
    input  logic              any_mode,
    output logic [DATA_W-1:0] lane_bits,
    output logic              hit
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] same;
    logic [DATA_W-1:0] care;

    // One enable byte per lane that lies within the byte count.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_bits[8*k +: 8] =
            ({{(32-CNT_W){1'b0}}, nbytes_m1} >= 32'(k)) ? 8'hFF : 8'h00;
    end

    // Apply the selected match rule over the considered bits.
    always_comb begin
        same = ~(status ^ match_val);
        care = mask & lane_bits;
        if (any_mode) hit = |(same & care);
        else          hit = &(same | ~care);
    end
endmodule

// File: rtl/poll_gap_timer.sv
// Interval timer: loaded with the programmed gap, counts down one step per
// serial clock tick and reports expiry at zero.
// Assumes: load and tick come from the sequencer and clock generator.
module poll_gap_timer #(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [INT_W-1:0] interval,
    output logic             expired
);
    logic [INT_W-1:0] remain;

    // Load on request, otherwise count down on each tick until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    remain <= '0;
        else if (load)                 remain <= interval;
        else if (tick && remain != '0) remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> (remain == $past(remain))); // R9
endmodule

// File: rtl/poll_sequencer.sv
// Polling sequencer: idle -> issue request -> wait for status -> gap -> issue.
// Abort takes priority in every state; a match with stop enabled returns
// the sequencer to idle.
// Assumes: hit is valid in the cycle rx_valid is high.
module poll_sequencer
    import poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic rx_valid,
    input  logic hit,
    input  logic stop_on_match,
    input  logic gap_expired,
    output logic busy,
    output logic rd_req,
    output logic accept,
    output logic load_gap
);
    poll_state_t state;

    // Decode the accept and reload strobes from the current state.
    always_comb begin
        accept   = (state == ST_WAIT) && rx_valid && !abort;
        load_gap = accept && !(hit && stop_on_match);
    end

    // Advance the polling state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (abort) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_ISSUE;
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT:  if (accept) state <= load_gap ? ST_GAP : ST_IDLE;
                ST_GAP:   if (gap_expired) state <= ST_ISSUE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign rd_req = (state == ST_ISSUE);

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R2
    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !abort) |=> rd_req); // R2
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !rd_req)); // R11
endmodule

// File: rtl/flash_status_poller.sv
// Flash status auto-polling engine top. It ties together the configuration
// capture, sequencer, gap timer and match evaluation, and holds the result
// flags and the last raw status word.
// Assumes: the front end returns rx_valid once per rd_req, bytes in low lanes.
module flash_status_poller #(
    parameter int DATA_W = 32,
    parameter int INT_W  = 16,
    localparam int LANES = DATA_W / 8,
    localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [DATA_W-1:0] cfg_match,
    input  logic              cfg_any_mode,
    input  logic              cfg_stop_on_match,
    input  logic [INT_W-1:0]  cfg_interval,
    input  logic [CNT_W-1:0]  cfg_nbytes_m1,
    input  logic              start,
    input  logic              abort,
    input  logic              sclk_tick,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              clr_match,
    input  logic              data_read,
    output logic              rd_req,
    output logic [CNT_W-1:0]  rd_len,
    output logic              match_flag,
    output logic              done_flag,
    output logic [DATA_W-1:0] last_status,
    output logic              busy
);
    logic [DATA_W-1:0] sh_mask, sh_match, lane_bits;
    logic              sh_any_mode, sh_stop, hit, accept, load_gap, gap_expired;
    logic [INT_W-1:0]  sh_interval;
    logic [CNT_W-1:0]  sh_nbytes_m1;

    poll_cfg_shadow #(.DATA_W(DATA_W), .INT_W(INT_W), .CNT_W(CNT_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .cfg_mask(cfg_mask), .cfg_match(cfg_match), .cfg_any_mode(cfg_any_mode),
        .cfg_stop_on_match(cfg_stop_on_match), .cfg_interval(cfg_interval),
        .cfg_nbytes_m1(cfg_nbytes_m1),
        .sh_mask(sh_mask), .sh_match(sh_match), .sh_any_mode(sh_any_mode),
        .sh_stop(sh_stop), .sh_interval(sh_interval), .sh_nbytes_m1(sh_nbytes_m1)
    );

    poll_match_eval #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_match (
        .status(rx_data), .mask(sh_mask), .match_val(sh_match),
        .nbytes_m1(sh_nbytes_m1), .any_mode(sh_any_mode),
        .lane_bits(lane_bits), .hit(hit)
    );

    poll_gap_timer #(.INT_W(INT_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(load_gap), .tick(sclk_tick),
        .interval(sh_interval), .expired(gap_expired)
    );

    poll_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .rx_valid(rx_valid), .hit(hit), .stop_on_match(sh_stop),
        .gap_expired(gap_expired), .busy(busy), .rd_req(rd_req),
        .accept(accept), .load_gap(load_gap)
    );

    assign rd_len = sh_nbytes_m1;

    // Sticky match flag: a new match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                match_flag <= 1'b0;
        else if (accept && hit)    match_flag <= 1'b1;
        else if (clr_match)        match_flag <= 1'b0;
    end

    // Read-done flag: set per accepted word, cleared by a software read.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_flag <= 1'b0;
        else if (accept)    done_flag <= 1'b1;
        else if (data_read) done_flag <= 1'b0;
    end

    // Keep the unmasked status, lanes above the byte count zeroed.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_status <= '0;
        else if (accept) last_status <= rx_data & lane_bits;
    end

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !clr_match) |=> match_flag); // R7
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> done_flag); // R8
    AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && sh_stop) |=> !busy); // R10
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(last_status)); // R13
endmodule

// File: tb/tb_flash_status_poller.sv
// Scoreboard bench: the driver pushes expected results into queues, and a
// monitor pops them and compares after each accepted status word.
module tb_flash_status_poller;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [31:0] cfg_mask = '0, cfg_match = '0, rx_data = '0;
    logic        cfg_any_mode = 1'b0, cfg_stop_on_match = 1'b0;
    logic [15:0] cfg_interval = '0;
    logic [1:0]  cfg_nbytes_m1 = '0;
    logic        start = 1'b0, abort = 1'b0, sclk_tick = 1'b1, rx_valid = 1'b0;
    logic        clr_match = 1'b0, data_read = 1'b0;
    logic        rd_req, match_flag, done_flag, busy;
    logic [1:0]  rd_len;
    logic [31:0] last_status;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    logic        expect_now = 1'b0;
    logic [31:0] exp_q[$];
    logic        expm_q[$];
    logic        exp_sticky = 1'b0;
    // bench copy of the configuration in force for the current run
    logic [31:0] m_mask, m_match;
    logic        m_any;
    logic [1:0]  m_nb;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_poller dut (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_match(cfg_match),
        .cfg_any_mode(cfg_any_mode), .cfg_stop_on_match(cfg_stop_on_match),
        .cfg_interval(cfg_interval), .cfg_nbytes_m1(cfg_nbytes_m1),
        .start(start), .abort(abort), .sclk_tick(sclk_tick),
        .rx_valid(rx_valid), .rx_data(rx_data), .clr_match(clr_match),
        .data_read(data_read), .rd_req(rd_req), .rd_len(rd_len),
        .match_flag(match_flag), .done_flag(done_flag),
        .last_status(last_status), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference match rule written from the requirements (R4, R5, R6).
    function automatic logic model_hit(input logic [31:0] s);
        logic any_eq = 1'b0, all_eq = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (m_mask[i] && (i / 8) <= int'(m_nb)) begin
                if (s[i] == m_match[i]) any_eq = 1'b1;
                else                    all_eq = 1'b0;
            end
        end
        return m_any ? any_eq : all_eq;
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] s);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) if ((i / 8) <= int'(m_nb)) r[i] = s[i];
        return r;
    endfunction

    task automatic latch_model();
        m_mask = cfg_mask; m_match = cfg_match; m_any = cfg_any_mode; m_nb = cfg_nbytes_m1;
    endtask

    // Wait for rd_req, counting negedges; ends at the negedge it is seen.
    task automatic wait_req(output int n);
        n = 0;
        while (rd_req !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    endtask

    // Deliver one status word and push its expected outcome.
    task automatic give_status(input logic [31:0] s);
        @(negedge clk);
        exp_sticky = exp_sticky | model_hit(s);
        exp_q.push_back(lanes(s));
        expm_q.push_back(exp_sticky);
        rx_data = s; rx_valid = 1'b1; expect_now = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; expect_now = 1'b0;
    endtask

    task automatic pulse_start();
        latch_model();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    // Monitor: compares outputs after every accepted word (R3, R4-R8).
    initial begin
        forever begin
            logic take;
            @(posedge clk);
            take = expect_now;
            @(negedge clk);
            if (take) begin
                logic [31:0] es; logic em;
                es = exp_q.pop_front(); em = expm_q.pop_front();
                chk("R3 last_status", last_status, es);
                chk("R4/R5/R6/R7 match_flag", {31'b0, match_flag}, {31'b0, em});
                chk("R8 done_flag set", {31'b0, done_flag}, 32'd1);
            end
        end
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 rd_req", {31'b0, rd_req}, 32'd0);
        chk("R1 flags", {30'b0, match_flag, done_flag}, 32'd0);
        chk("R1 last_status", last_status, 32'd0);

        // AND rule, one byte, stop on match, interval 3
        cfg_mask = 32'h03; cfg_match = 32'h01; cfg_any_mode = 1'b0;
        cfg_stop_on_match = 1'b1; cfg_interval = 16'd3; cfg_nbytes_m1 = 2'd0;
        pulse_start();
        chk("R2 busy after start", {31'b0, busy}, 32'd1);
        chk("R2 rd_req after start", {31'b0, rd_req}, 32'd1);
        chk("R2 rd_len", {30'b0, rd_len}, 32'd0);
        give_status(32'h0000_0003);                 // R4 no match
        wait_req(n);
        chk("R9 gap interval 3", n, 32'd4);
        give_status(32'h0000_00F1);                 // R4 match -> R10 stop
        chk("R10 busy low after stop match", {31'b0, busy}, 32'd0);
        wait_req(n);
        chk("R10 no request after stop", {31'b0, rd_req}, 32'd0);

        // OR rule, continuous polling, interval 0
        data_read = 1'b1; @(negedge clk); data_read = 1'b0;
        chk("R8 done cleared by data_read", {31'b0, done_flag}, 32'd0);
        clr_match = 1'b1; @(negedge clk); clr_match = 1'b0; exp_sticky = 1'b0;
        chk("R7 match cleared", {31'b0, match_flag}, 32'd0);
        cfg_any_mode = 1'b1; cfg_mask = 32'hF0; cfg_match = 32'hA0;
        cfg_stop_on_match = 1'b0; cfg_interval = 16'd0;
        pulse_start();
        give_status(32'h0000_0050);                 // R5 all considered differ
        wait_req(n);
        chk("R9 gap interval 0", n, 32'd1);
        give_status(32'h0000_0010);                 // R5 one bit equal
        chk("R10 continues after match", {31'b0, busy}, 32'd1);
        wait_req(n);
        chk("R10 request after match", {31'b0, rd_req}, 32'd1);
        give_status(32'h0000_005F);                 // R7 flag stays set
        wait_req(n);
        clr_match = 1'b1; @(negedge clk); clr_match = 1'b0; exp_sticky = 1'b0;
        chk("R7 clear while polling", {31'b0, match_flag}, 32'd0);
        cfg_mask = 32'h0F; cfg_match = 32'h00; cfg_interval = 16'd9; // R12
        give_status(32'h0000_0050);                 // old config: no match
        wait_req(n);
        chk("R12 interval frozen", n, 32'd1);
        data_read = 1'b1; @(negedge clk); data_read = 1'b0;
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk("R11 busy low after abort", {31'b0, busy}, 32'd0);
        rx_data = 32'hAA; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
        chk("R13 done unchanged", {31'b0, done_flag}, 32'd0);
        chk("R13 status unchanged", last_status, 32'h50);
        wait_req(n);
        chk("R11 no request after abort", {31'b0, rd_req}, 32'd0);

        // Lane limit: two bytes, AND rule, upper bytes excluded (R6)
        cfg_any_mode = 1'b0; cfg_mask = 32'hFFFF_FF00; cfg_match = 32'h1234_5600;
        cfg_stop_on_match = 1'b1; cfg_interval = 16'd2; cfg_nbytes_m1 = 2'd1;
        pulse_start();
        chk("R2 rd_len two bytes", {30'b0, rd_len}, 32'd1);
        give_status(32'hAAAA_5678);
        chk("R6 stop on lane-limited match", {31'b0, busy}, 32'd0);

        // Empty mask in OR rule, four bytes, tick pauses (R5, R9)
        clr_match = 1'b1; @(negedge clk); clr_match = 1'b0; exp_sticky = 1'b0;
        cfg_any_mode = 1'b1; cfg_mask = 32'h0; cfg_stop_on_match = 1'b0;
        cfg_nbytes_m1 = 2'd3;
        pulse_start();
        give_status(32'hFFFF_FFFF);
        sclk_tick = 1'b0;
        n = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (rd_req) n++; end
        chk("R9 no request without ticks", n, 32'd0);
        sclk_tick = 1'b1;
        wait_req(n);
        chk("R9 gap after tick pause", n, 32'd3);
        give_status(32'h1234_5678);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk("R11 abort ends run", {31'b0, busy}, 32'd0);
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule